// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-wire serial control link. A host lowers the chip-select line, clocks in a 16-bit command word and then moves one or more bytes over a single shared data pin. The block turns each frame into accesses on a simple byte-wide register-file port. That port carries an address, write data, a one-cycle write strobe and combinational read data. The register file itself sits outside the block.

The serial clock, the chip-select line and the data pin are all sampled by a faster system clock, through a chain of synchronising flops. Every serial event is therefore seen as an edge in the system-clock domain. On a read, the block takes over the data pin through an output-enable signal that goes to a tri-state pad. It gives the pin back as soon as the last byte is done or the frame is cut short.

Top module: `spi3w_regport`

## Requirements
- R1: A falling edge on `csb_i` starts a frame. The next 16 rising edges of `sclk_i` capture the command from `sdio_i`, most significant bit first. Bit 15 selects the direction (1 = read, 0 = write), bits 14:13 hold the length code, and bits 12:0 hold the starting register address.
- R2: The length code 00 moves one data byte, 01 two, 10 three, and 11 keeps moving bytes until `csb_i` rises. Clock edges after the counted bytes cause no write and no output drive.
- R3: In a write frame, each data byte is taken from `sdio_i` on rising edges, most significant bit first. Each complete byte gives exactly one single-cycle `reg_wr` pulse, with `reg_addr` and `reg_wdata` valid in that cycle, and a read frame never pulses `reg_wr`.
- R4: After each completed data byte, the register address moves down by one. The first byte of a frame uses the commanded address.
- R5: In a read frame, the byte `reg_rdata` at the current address leaves on `sdio_o`, most significant bit first. Each bit changes after a falling edge of `sclk_i` and is held for the following rising edge. The first bit follows the falling edge after the 16th rising edge.
- R6: `sdio_oe` stays low while idle, during the command and during write data. It rises only after the falling edge that opens the read data phase. It drops after the rising edge that completes the last counted read byte.
- R7: A rise of `csb_i` at any point ends the frame. A partially shifted byte is dropped without a write, `sdio_oe` falls, and the next falling edge of `csb_i` starts a fresh command.
- R8: While `csb_i` is high, activity on `sclk_i` and `sdio_i` causes no write and no output drive, and it leaves no trace in the next frame.
- R9: While reset is held, and after it is released with no frame, `sdio_oe` and `reg_wr` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| csb_i | input | 1 | Active-low frame select from the host |
| sdio_i | input | 1 | Level seen on the shared data pin |
| sdio_o | output | 1 | Read data driven onto the shared pin |
| sdio_oe | output | 1 | Drive enable for the data pin's tri-state buffer |
| reg_addr | output | 13 | Register address for the current byte |
| reg_wdata | output | 8 | Byte to be written |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Byte read combinationally at `reg_addr` |

## Verification
The bench builds the block with its default parameters: a 13-bit address, so the full command word is exercised, and two synchroniser stages. The serial clock runs with phases of eight system cycles. With these values, an odd high-order address can be checked exactly at the write strobe. The bench can also sample the output-enable on either side of the turnaround falling edge, and it can cut frames mid-byte while the synchroniser latency is still fully in play.

// File: rtl/spi3w_pkg.sv
`timescale 1ns/1ps
package spi3w_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INSTR = 3'd1,
    ST_WRITE = 3'd2,
    ST_READ  = 3'd3,
    ST_DONE  = 3'd4
  } spi3w_state_e;

  localparam logic [1:0] LEN_STREAM = 2'b11;

endpackage

// File: rtl/spi3w_sync.sv
`timescale 1ns/1ps
module spi3w_sync #(
  parameter int             N_SIG   = 3,
  parameter int             STAGES  = 2,
  parameter logic [N_SIG-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SIG-1:0] async_i,
  output logic [N_SIG-1:0] sync_o
);

  for (genvar g = 0; g < N_SIG; g++) begin : g_chain
    logic [STAGES-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= {STAGES{RST_VAL[g]}};
      end else begin
        stage_q <= {stage_q[STAGES-2:0], async_i[g]};
      end
    end

    assign sync_o[g] = stage_q[STAGES-1];
  end

endmodule

// File: rtl/spi3w_edge.sv
`timescale 1ns/1ps
module spi3w_edge #(
  parameter int             N_SIG   = 2,
  parameter logic [N_SIG-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SIG-1:0] lvl_i,
  output logic [N_SIG-1:0] rise_o,
  output logic [N_SIG-1:0] fall_o
);

  logic [N_SIG-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= RST_VAL;
    end else begin
      prev_q <= lvl_i;
    end
  end

  for (genvar g = 0; g < N_SIG; g++) begin : g_det
    assign rise_o[g] =  lvl_i[g] & ~prev_q[g];
    assign fall_o[g] = ~lvl_i[g] &  prev_q[g];
  end

endmodule

// File: rtl/spi3w_ctrl.sv
`timescale 1ns/1ps
module spi3w_ctrl
  import spi3w_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              csb_lvl,
  input  logic              csb_fall,
  input  logic              csb_rise,
  input  logic              sdio_bit,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int INSTR_W = ADDR_W + 3;
  localparam int CNT_W   = $clog2(INSTR_W);
  localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(INSTR_W - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(DATA_W - 1);

  spi3w_state_e        st_q, st_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [INSTR_W-2:0]  ins_q, ins_n;
  logic                rw_q, rw_n;
  logic [1:0]          len_q, len_n;
  logic [1:0]          byte_q, byte_n;
  logic [ADDR_W-1:0]   addr_q, addr_n;
  logic [DATA_W-1:0]   rx_q, rx_n;
  logic [DATA_W-1:0]   tx_q, tx_n;
  logic [DATA_W-1:0]   wdata_q, wdata_n;
  logic                oe_q, oe_n;
  logic                wr_q, wr_n;
  logic                dec_q, dec_n;
  logic                last_byte;

  assign last_byte = (len_q != LEN_STREAM) && (byte_q == len_q);

  // next-state logic
  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    ins_n   = ins_q;
    rw_n    = rw_q;
    len_n   = len_q;
    byte_n  = byte_q;
    addr_n  = addr_q;
    rx_n    = rx_q;
    tx_n    = tx_q;
    wdata_n = wdata_q;
    oe_n    = oe_q;
    wr_n    = 1'b0;
    dec_n   = 1'b0;

    if (dec_q) begin
      addr_n = addr_q - 1'b1;
    end

    if (csb_lvl) begin
      st_n  = ST_IDLE;
      oe_n  = 1'b0;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (csb_fall) begin
            st_n   = ST_INSTR;
            cnt_n  = '0;
            byte_n = '0;
          end
        end
        ST_INSTR: begin
          if (sclk_rise) begin
            if (cnt_q == INSTR_LAST) begin
              rw_n   = ins_q[INSTR_W-2];
              len_n  = ins_q[INSTR_W-3 -: 2];
              addr_n = {ins_q[ADDR_W-2:0], sdio_bit};
              cnt_n  = '0;
              st_n   = ins_q[INSTR_W-2] ? ST_READ : ST_WRITE;
            end else begin
              ins_n  = {ins_q[INSTR_W-3:0], sdio_bit};
              cnt_n  = cnt_q + 1'b1;
            end
          end
        end
        ST_WRITE: begin
          if (sclk_rise) begin
            rx_n = {rx_q[DATA_W-2:0], sdio_bit};
            if (cnt_q == BYTE_LAST) begin
              wdata_n = {rx_q[DATA_W-2:0], sdio_bit};
              wr_n    = 1'b1;
              dec_n   = 1'b1;
              cnt_n   = '0;
              byte_n  = byte_q + 1'b1;
              if (last_byte) begin
                st_n = ST_DONE;
              end
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_READ: begin
          if (sclk_fall) begin
            oe_n = 1'b1;
            tx_n = (cnt_q == '0) ? reg_rdata : {tx_q[DATA_W-2:0], 1'b0};
          end
          if (sclk_rise) begin
            if (cnt_q == BYTE_LAST) begin
              cnt_n  = '0;
              addr_n = addr_q - 1'b1;
              byte_n = byte_q + 1'b1;
              if (last_byte) begin
                st_n = ST_DONE;
                oe_n = 1'b0;
              end
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_DONE: begin
          st_n = ST_DONE;
        end
        default: begin
          st_n = ST_IDLE;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      ins_q   <= '0;
      rw_q    <= 1'b0;
      len_q   <= '0;
      byte_q  <= '0;
      addr_q  <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
      dec_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      ins_q   <= ins_n;
      rw_q    <= rw_n;
      len_q   <= len_n;
      byte_q  <= byte_n;
      addr_q  <= addr_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      wdata_q <= wdata_n;
      oe_q    <= oe_n;
      wr_q    <= wr_n;
      dec_q   <= dec_n;
    end
  end

  assign sdio_o    = tx_q[DATA_W-1];
  assign sdio_oe   = oe_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_wr    = wr_q;

  // R6
  oe_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (st_q == ST_READ));

  // R7
  csb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csb_lvl |=> !oe_q);

  // R7
  csb_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csb_rise |=> (st_q == ST_IDLE));

  // R3
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);

  // R3
  wr_not_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> !rw_q);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> (addr_q == $past(addr_q) - 1'b1));

endmodule

// File: rtl/spi3w_regport.sv
`timescale 1ns/1ps
module spi3w_regport #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csb_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  input  logic [DATA_W-1:0] reg_rdata
);

  // bit order of the synchronised vector: {sdio, csb, sclk}
  localparam logic [2:0] PIN_RST  = 3'b010;
  localparam logic [1:0] EDGE_RST = PIN_RST[1:0];

  logic [2:0] pin_s;
  logic [1:0] pin_rise;
  logic [1:0] pin_fall;

  spi3w_sync #(
    .N_SIG   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sdio_i, csb_i, sclk_i}),
    .sync_o  (pin_s)
  );

  spi3w_edge #(
    .N_SIG   (2),
    .RST_VAL (EDGE_RST)
  ) edge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (pin_s[1:0]),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  spi3w_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_rise (pin_rise[0]),
    .sclk_fall (pin_fall[0]),
    .csb_lvl   (pin_s[1]),
    .csb_fall  (pin_fall[1]),
    .csb_rise  (pin_rise[1]),
    .sdio_bit  (pin_s[2]),
    .sdio_o    (sdio_o),
    .sdio_oe   (sdio_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata)
  );

endmodule

// File: tb/spi3w_regport_tb.sv
`timescale 1ns/1ps
module spi3w_regport_tb_top;

  localparam int HALF = 40;

  logic        clk;
  logic        rst_n;
  logic        sclk;
  logic        csb;
  logic        sdio_drv;
  logic        sdio_o;
  logic        sdio_oe;
  logic [12:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic        reg_wr;
  logic [7:0]  reg_rdata;
  logic        sdio_line;

  logic [7:0]  mem [64];
  logic [7:0]  expm [64];
  int          wr_cnt;
  logic [12:0] last_wr_addr;
  int          n_chk;
  int          n_bad;
  bit          finished;

  assign sdio_line = sdio_oe ? sdio_o : sdio_drv;
  assign reg_rdata = mem[reg_addr[5:0]];

  spi3w_regport dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (sclk),
    .csb_i     (csb),
    .sdio_i    (sdio_line),
    .sdio_o    (sdio_o),
    .sdio_oe   (sdio_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37) + 5);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= pat(i);
      wr_cnt <= 0;
      last_wr_addr <= '0;
    end else if (reg_wr) begin
      mem[reg_addr[5:0]] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
      last_wr_addr <= reg_addr;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  // one serial bit, entered and left with sclk low
  task automatic clk_bit(input logic b, output logic smp);
    sdio_drv = b;
    #HALF;
    smp  = sdio_line;
    sclk = 1'b1;
    #HALF;
    sclk = 1'b0;
  endtask

  task automatic frame_open();
    csb = 1'b0;
    #HALF;
  endtask

  task automatic frame_close();
    #HALF;
    csb = 1'b1;
    #(4 * HALF);
  endtask

  // command word; counts output-enable samples seen; optionally checks the turnaround
  task automatic send_cmd(input logic rw, input logic [1:0] len, input logic [12:0] addr,
                          input bit chk_turn, output int oe_seen);
    logic [15:0] w;
    logic        s;
    w = {rw, len, addr};
    oe_seen = 0;
    for (int i = 15; i >= 1; i--) begin
      clk_bit(w[i], s);
      if (sdio_oe) oe_seen++;
    end
    sdio_drv = w[0];
    #HALF;
    sclk = 1'b1;
    #(HALF - 1);
    if (sdio_oe) oe_seen++;
    if (chk_turn) check(sdio_oe == 1'b0, "R6 oe before turnaround fall", int'(sdio_oe), 0);
    #1;
    sclk = 1'b0;
  endtask

  task automatic xfer_byte(input logic [7:0] w, output logic [7:0] r);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(w[i], s);
      r[i] = s;
    end
  endtask

  task automatic t_reset();
    check(sdio_oe == 1'b0, "R9 oe after reset", int'(sdio_oe), 0);
    check(reg_wr == 1'b0 && wr_cnt == 0, "R9 no write after reset", wr_cnt, 0);
  endtask

  task automatic t_write_single();
    int oe_seen; int w0; logic [7:0] r;
    w0 = wr_cnt;
    frame_open();
    send_cmd(1'b0, 2'b00, 13'h1A55, 1'b0, oe_seen);
    xfer_byte(8'hC3, r);
    xfer_byte(8'h5A, r);
    frame_close();
    expm[6'h15] = 8'hC3;
    check(mem[6'h15] == 8'hC3, "R3 single byte written", int'(mem[6'h15]), 'hC3);
    check(last_wr_addr == 13'h1A55, "R1 full address decoded", int'(last_wr_addr), 'h1A55);
    check(wr_cnt - w0 == 1, "R2 one byte for code 00", wr_cnt - w0, 1);
    check(mem[6'h14] == expm[6'h14], "R2 extra byte ignored", int'(mem[6'h14]), int'(expm[6'h14]));
    check(oe_seen == 0 && sdio_oe == 1'b0, "R6 no drive in write frame", oe_seen, 0);
  endtask

  task automatic t_write_multi();
    int oe_seen; int w0; logic [7:0] r;
    w0 = wr_cnt;
    frame_open();
    send_cmd(1'b0, 2'b10, 13'h0022, 1'b0, oe_seen);
    xfer_byte(8'hA1, r);
    xfer_byte(8'hB2, r);
    xfer_byte(8'hC3, r);
    xfer_byte(8'hFF, r);
    frame_close();
    expm[6'h22] = 8'hA1; expm[6'h21] = 8'hB2; expm[6'h20] = 8'hC3;
    check(mem[6'h22] == 8'hA1, "R4 first byte at start address", int'(mem[6'h22]), 'hA1);
    check(mem[6'h21] == 8'hB2, "R4 second byte one lower", int'(mem[6'h21]), 'hB2);
    check(mem[6'h20] == 8'hC3, "R4 third byte two lower", int'(mem[6'h20]), 'hC3);
    check(mem[6'h1F] == expm[6'h1F], "R2 fourth byte ignored for code 10", int'(mem[6'h1F]), int'(expm[6'h1F]));
    check(wr_cnt - w0 == 3, "R3 one strobe per byte", wr_cnt - w0, 3);
  endtask

  task automatic t_read_two();
    int oe_seen; int w0; logic [7:0] r;
    w0 = wr_cnt;
    frame_open();
    send_cmd(1'b1, 2'b01, 13'h0021, 1'b1, oe_seen);
    check(oe_seen == 0, "R6 no drive during command", oe_seen, 0);
    #(HALF / 2);
    check(sdio_oe == 1'b1, "R6 drive after turnaround fall", int'(sdio_oe), 1);
    #(HALF / 2);
    xfer_byte(8'h00, r);
    check(r == 8'hB2, "R5 read byte at start address", int'(r), 'hB2);
    xfer_byte(8'h00, r);
    check(r == 8'hC3, "R5 read byte one lower", int'(r), 'hC3);
    check(sdio_oe == 1'b0, "R6 released after last byte", int'(sdio_oe), 0);
    xfer_byte(8'hFF, r);
    check(sdio_oe == 1'b0, "R2 no drive past count", int'(sdio_oe), 0);
    frame_close();
    check(wr_cnt == w0, "R3 read frame does not write", wr_cnt - w0, 0);
  endtask

  task automatic t_stream();
    int oe_seen; int w0; logic [7:0] r; int bad;
    logic [7:0] d [5];
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44; d[4] = 8'h55;
    w0 = wr_cnt;
    frame_open();
    send_cmd(1'b0, 2'b11, 13'h000C, 1'b0, oe_seen);
    for (int i = 0; i < 5; i++) begin
      xfer_byte(d[i], r);
      expm[6'h0C - i] = d[i];
    end
    frame_close();
    check(wr_cnt - w0 == 5, "R2 streaming write length", wr_cnt - w0, 5);
    bad = 0;
    frame_open();
    send_cmd(1'b1, 2'b11, 13'h000C, 1'b0, oe_seen);
    for (int i = 0; i < 5; i++) begin
      xfer_byte(8'h00, r);
      if (r != d[i]) begin
        bad++;
        check(1'b0, "R5 streaming read data", int'(r), int'(d[i]));
      end
    end
    check(sdio_oe == 1'b1, "R2 stream keeps driving until csb", int'(sdio_oe), 1);
    frame_close();
    check(bad == 0, "R4 streaming address sequence", bad, 0);
  endtask

  task automatic t_abort_write();
    int oe_seen; int w0; logic s; logic [7:0] r;
    w0 = wr_cnt;
    frame_open();
    send_cmd(1'b0, 2'b00, 13'h0030, 1'b0, oe_seen);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    frame_close();
    check(wr_cnt == w0, "R7 partial byte dropped", wr_cnt - w0, 0);
    check(mem[6'h30] == expm[6'h30], "R7 target unchanged", int'(mem[6'h30]), int'(expm[6'h30]));
    frame_open();
    send_cmd(1'b0, 2'b00, 13'h0030, 1'b0, oe_seen);
    xfer_byte(8'h6E, r);
    frame_close();
    expm[6'h30] = 8'h6E;
    check(mem[6'h30] == 8'h6E, "R7 fresh command after abort", int'(mem[6'h30]), 'h6E);
  endtask

  task automatic t_abort_read();
    int oe_seen; logic s; logic [7:0] r;
    frame_open();
    send_cmd(1'b1, 2'b11, 13'h000A, 1'b0, oe_seen);
    xfer_byte(8'h00, r);
    check(r == expm[6'h0A], "R5 read before abort", int'(r), int'(expm[6'h0A]));
    for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
    #HALF;
    csb = 1'b1;
    #(2 * HALF);
    check(sdio_oe == 1'b0, "R7 drive released on csb rise", int'(sdio_oe), 1'b0);
    #(2 * HALF);
  endtask

  task automatic t_csb_high();
    int oe_seen; int w0; int oe_hi; logic s; logic [7:0] r;
    w0 = wr_cnt;
    oe_hi = 0;
    for (int i = 0; i < 24; i++) begin
      clk_bit(i[0] ^ i[2], s);
      if (sdio_oe) oe_hi++;
    end
    #(2 * HALF);
    check(wr_cnt == w0 && oe_hi == 0, "R8 clocks ignored with csb high", wr_cnt - w0 + oe_hi, 0);
    frame_open();
    send_cmd(1'b1, 2'b00, 13'h0009, 1'b0, oe_seen);
    xfer_byte(8'h00, r);
    frame_close();
    check(r == expm[6'h09], "R8 next frame unaffected", int'(r), int'(expm[6'h09]));
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    finished = 1'b0;
    for (int i = 0; i < 64; i++) expm[i] = pat(i);
    rst_n = 1'b0;
    sclk = 1'b0;
    csb = 1'b1;
    sdio_drv = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    check(sdio_oe == 1'b0 && reg_wr == 1'b0, "R9 outputs in reset", int'({sdio_oe, reg_wr}), 0);
    rst_n = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    t_reset();
    t_write_single();
    t_write_multi();
    t_read_two();
    t_stream();
    t_abort_write();
    t_abort_read();
    t_csb_high();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule